// File: doc/BRIEF.md
# Indirect Branch Landing-Pad Checker

This block sits beside the retire stage of a small 32-bit core. It enforces forward-edge control-flow integrity. When tracking is enabled and a register-indirect jump retires, the block remembers that the next retired instruction must be a landing pad. A landing pad is an upper-immediate-add-to-PC instruction whose destination is the zero register, and it carries a 20-bit label.

On the next retire the block does one of two things:
- It signals a pass, if the landing pad is word-aligned and either its label is zero or the label equals the upper 20 bits of register x7.
- Otherwise it raises a software-check exception, with cause code 18 and trap value 2.

Indirect jumps through x1, x5 or x7 do not arm the check. Jumps through x1 or x5 are returns, and jumps through x7 are software-guarded jumps. A configuration write port sets the per-task enable and a sticky lock. Once the lock is set, the enable can no longer be cleared.

Top module: `lpad_checker`

## Requirements
- R1: After a synchronous reset, the block is disabled, unlocked and unarmed, and neither `lp_ok_o` nor `viol_o` is asserted.
- R2: With tracking enabled, a retired jump (opcode 1100111, funct3 000, rs1 in bits 19:15) arms the block from the following cycle, provided its rs1 is not exempt.
- R3: A retired jump whose rs1 is x1, x5 or x7 does not arm the block.
- R4: A landing pad (opcode 0010111 with rd, bits 11:7, equal to zero) that retires while the block is unarmed produces neither a pass nor a violation.
- R5: When armed, a retired instruction that is not a landing pad raises a violation. This includes an upper-immediate-add with a nonzero rd.
- R6: When armed, a landing pad whose PC bits 1:0 are not zero raises a violation.
- R7: When armed, a word-aligned landing pad whose label (bits 31:12) is zero passes, whatever the value of x7.
- R8: When armed, a word-aligned landing pad with a nonzero label passes only if the label equals x7 bits 31:12. Otherwise it raises a violation.
- R9: `viol_o` and `lp_ok_o` are asserted in the same cycle as the retire strobe of the checked instruction, for that one cycle only. While `viol_o` is high, the cause is 18 and the trap value is 2. Both are zero otherwise.
- R10: The armed state survives cycles with no retire, and clears after the next retired instruction, whether that instruction passes or fails.
- R11: A trap taken for another reason (`other_trap_i`) clears the armed state, and prevents a jump retiring in the same cycle from arming.
- R12: A configuration write sets the enable to the written value. While the enable is low, nothing arms and no violation or pass is raised. Clearing the enable also clears the armed state.
- R13: A configuration write with the lock bit set makes the lock sticky until reset. While the block is locked, a write that tries to clear the enable leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid_i | input | 1 | An instruction retires this cycle |
| ret_insn_i | input | 32 | Retiring instruction word |
| ret_pc_i | input | 32 | PC of the retiring instruction |
| x7_val_i | input | 32 | Current value of register x7 |
| other_trap_i | input | 1 | A trap for another reason is taken this cycle |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Enable value written |
| cfg_lock_i | input | 1 | Lock request written |
| lp_ok_o | output | 1 | Landing-pad check passed |
| viol_o | output | 1 | Software-check exception request |
| viol_cause_o | output | 5 | Exception cause code |
| viol_tval_o | output | 32 | Exception trap value |
| armed_o | output | 1 | Expecting a landing pad on the next retire |
| track_en_o | output | 1 | Current tracking enable |

## Verification
The verdict outputs are combinational from the armed register and the retire inputs, so the result for an instruction is due in the same cycle as its retire strobe. `armed_o` and `track_en_o` change one clock edge after the jump or configuration write that causes them. The bench drives each cycle's inputs at the falling edge and compares all outputs against a behavioural model shortly afterwards, before the next rising edge. The model's state advances only after that comparison, so each result is judged in the cycle in which it is due.

// File: rtl/lpad_pkg.sv
`timescale 1ns/1ps
package lpad_pkg;
    localparam int XLEN    = 32;
    localparam int LBL_W   = 20;
    localparam int CAUSE_W = 5;
    localparam int REG_W   = 5;

    localparam logic [6:0] OPC_JALR  = 7'b1100111;
    localparam logic [6:0] OPC_AUIPC = 7'b0010111;

    typedef struct packed {
        logic             is_jump;
        logic             is_pad;
        logic             exempt;
        logic [REG_W-1:0] src;
        logic [LBL_W-1:0] label;
    } insn_info_t;

    typedef enum logic [1:0] {
        V_NONE = 2'd0,
        V_PASS = 2'd1,
        V_FAIL = 2'd2
    } verdict_e;
endpackage

// File: rtl/lpad_decode.sv
`timescale 1ns/1ps
module lpad_decode
    import lpad_pkg::*;
#(
    parameter logic [31:0] EXEMPT_MASK = 32'h0000_00A2
) (
    input  logic [XLEN-1:0] insn_i,
    output insn_info_t      info_o
);
    localparam int LBL_LSB = XLEN - LBL_W;

    logic [6:0]       opcode;
    logic [REG_W-1:0] rd;
    logic [2:0]       funct3;
    logic [REG_W-1:0] rs1;

    always_comb begin
        opcode = insn_i[6:0];
        rd     = insn_i[11:7];
        funct3 = insn_i[14:12];
        rs1    = insn_i[19:15];
        info_o.is_jump = (opcode == OPC_JALR) && (funct3 == 3'b000);
        info_o.is_pad  = (opcode == OPC_AUIPC) && (rd == '0);
        info_o.exempt  = EXEMPT_MASK[rs1];
        info_o.src     = rs1;
        info_o.label   = insn_i[XLEN-1:LBL_LSB];
    end
endmodule

// File: rtl/lpad_cfg.sv
`timescale 1ns/1ps
module lpad_cfg (
    input  logic clk,
    input  logic rst,
    input  logic wr_i,
    input  logic en_i,
    input  logic lock_i,
    output logic en_o,
    output logic en_next_o,
    output logic lock_o
);
    logic en_q, lock_q;

    always_comb begin
        en_next_o = en_q;
        if (wr_i && !(lock_q && !en_i))
            en_next_o = en_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            en_q   <= en_next_o;
            lock_q <= lock_q | (wr_i & lock_i);
        end
    end

    assign en_o   = en_q;
    assign lock_o = lock_q;

    // R13: once locked, the enable cannot fall
    a_r13_lock_keeps_enable: assert property (@(posedge clk) disable iff (rst)
        (lock_q && en_q) |=> en_q);
    // R13: the lock is sticky
    a_r13_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q);
endmodule

// File: rtl/lpad_verdict.sv
`timescale 1ns/1ps
module lpad_verdict
    import lpad_pkg::*;
(
    input  logic             check_i,
    input  insn_info_t       info_i,
    input  logic [1:0]       pc_lo_i,
    input  logic [LBL_W-1:0] x7_label_i,
    output verdict_e         verdict_o
);
    logic aligned, label_ok, good;

    always_comb begin
        aligned  = (pc_lo_i == 2'b00);
        label_ok = (info_i.label == '0) || (info_i.label == x7_label_i);
        good     = info_i.is_pad && aligned && label_ok;
        if (!check_i)  verdict_o = V_NONE;
        else if (good) verdict_o = V_PASS;
        else           verdict_o = V_FAIL;
    end
endmodule

// File: rtl/lpad_checker.sv
`timescale 1ns/1ps
module lpad_checker
    import lpad_pkg::*;
#(
    parameter logic [31:0]         EXEMPT_MASK = 32'h0000_00A2,
    parameter logic [CAUSE_W-1:0]  CAUSE_CODE  = 5'd18,
    parameter logic [XLEN-1:0]     TVAL_CODE   = 32'd2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ret_valid_i,
    input  logic [XLEN-1:0]     ret_insn_i,
    input  logic [XLEN-1:0]     ret_pc_i,
    input  logic [XLEN-1:0]     x7_val_i,
    input  logic                other_trap_i,
    input  logic                cfg_wr_i,
    input  logic                cfg_en_i,
    input  logic                cfg_lock_i,
    output logic                lp_ok_o,
    output logic                viol_o,
    output logic [CAUSE_W-1:0]  viol_cause_o,
    output logic [XLEN-1:0]     viol_tval_o,
    output logic                armed_o,
    output logic                track_en_o
);
    localparam int LBL_LSB = XLEN - LBL_W;

    insn_info_t info;
    verdict_e   verdict;
    logic       en_q, en_next, lock_q;
    logic       armed_q, armed_d, check;
    logic       unused_bits;

    assign unused_bits = ^{ret_pc_i[XLEN-1:2], x7_val_i[LBL_LSB-1:0], lock_q, info.src};

    lpad_decode #(.EXEMPT_MASK(EXEMPT_MASK)) u_decode (
        .insn_i (ret_insn_i),
        .info_o (info)
    );

    lpad_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (cfg_wr_i),
        .en_i      (cfg_en_i),
        .lock_i    (cfg_lock_i),
        .en_o      (en_q),
        .en_next_o (en_next),
        .lock_o    (lock_q)
    );

    assign check = en_q && armed_q && ret_valid_i;

    lpad_verdict u_verdict (
        .check_i    (check),
        .info_i     (info),
        .pc_lo_i    (ret_pc_i[1:0]),
        .x7_label_i (x7_val_i[XLEN-1:LBL_LSB]),
        .verdict_o  (verdict)
    );

    always_comb begin
        if (!en_q || !en_next || other_trap_i)
            armed_d = 1'b0;
        else if (ret_valid_i)
            armed_d = !armed_q && info.is_jump && !info.exempt;
        else
            armed_d = armed_q;
    end

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= armed_d;
    end

    always_comb begin
        lp_ok_o      = (verdict == V_PASS);
        viol_o       = (verdict == V_FAIL);
        viol_cause_o = viol_o ? CAUSE_CODE : '0;
        viol_tval_o  = viol_o ? TVAL_CODE  : '0;
    end

    assign armed_o    = armed_q;
    assign track_en_o = en_q;

    // R9: verdicts only accompany a retire strobe
    a_r9_verdict_on_retire: assert property (@(posedge clk) disable iff (rst)
        (viol_o || lp_ok_o) |-> ret_valid_i);
    // R10: a checked retire always disarms
    a_r10_single_check: assert property (@(posedge clk) disable iff (rst)
        (ret_valid_i && armed_q) |=> !armed_q);
    // R11: another trap disarms
    a_r11_trap_disarms: assert property (@(posedge clk) disable iff (rst)
        other_trap_i |=> !armed_q);
    // R12: disabled means idle
    a_r12_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> (!armed_q && !viol_o && !lp_ok_o));
    // R3: exempt sources never arm
    a_r3_exempt_no_arm: assert property (@(posedge clk) disable iff (rst)
        (ret_valid_i && !armed_q && info.is_jump && info.exempt) |=> !armed_q);
    // R5: a non-pad after an armed jump is a violation
    a_r5_missing_pad: assert property (@(posedge clk) disable iff (rst)
        (en_q && armed_q && ret_valid_i && !info.is_pad) |-> viol_o);
    // R7: zero label on an aligned pad always passes
    a_r7_zero_label: assert property (@(posedge clk) disable iff (rst)
        (en_q && armed_q && ret_valid_i && info.is_pad && info.label == '0
         && ret_pc_i[1:0] == 2'b00) |-> lp_ok_o);
endmodule

// File: tb/lpad_checker_bench.sv
`timescale 1ns/1ps
module lpad_checker_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst, rv, trap, cwr, cen, clk_lock;
    logic [31:0] insn, pc, x7;
    logic        lp_ok, viol, armed, ten;
    logic [4:0]  cause;
    logic [31:0] tval;

    lpad_checker u_lpad_checker (
        .clk(clk), .rst(rst), .ret_valid_i(rv), .ret_insn_i(insn), .ret_pc_i(pc),
        .x7_val_i(x7), .other_trap_i(trap), .cfg_wr_i(cwr), .cfg_en_i(cen),
        .cfg_lock_i(clk_lock), .lp_ok_o(lp_ok), .viol_o(viol), .viol_cause_o(cause),
        .viol_tval_o(tval), .armed_o(armed), .track_en_o(ten)
    );

    int nvec = 0, nfail = 0;
    bit m_en = 0, m_lock = 0, m_armed = 0;

    // next-cycle stimulus
    logic        n_rst = 1, n_rv = 0, n_trap = 0, n_wr = 0, n_en = 0, n_lk = 0;
    logic [31:0] n_insn = 32'h13, n_pc = 0, n_x7 = 0;

    function automatic logic [31:0] jalr(input int rs1, input int rd);
        return {12'h010, rs1[4:0], 3'b000, rd[4:0], 7'b1100111};
    endfunction
    function automatic logic [31:0] lpad(input logic [19:0] lbl);
        return {lbl, 5'd0, 7'b0010111};
    endfunction
    localparam logic [31:0] NOP = 32'h0000_0013;

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input string tag);
        bit is_jump, is_pad, exempt, good, chk, e_ok, e_viol, en_nx;
        @(negedge clk);
        rst = n_rst; rv = n_rv; insn = n_insn; pc = n_pc; x7 = n_x7;
        trap = n_trap; cwr = n_wr; cen = n_en; clk_lock = n_lk;
        #1;
        is_jump = (insn[6:0] == 7'b1100111) && (insn[14:12] == 3'b000);
        is_pad  = (insn[6:0] == 7'b0010111) && (insn[11:7] == 5'd0);
        exempt  = (insn[19:15] == 5'd1) || (insn[19:15] == 5'd5) || (insn[19:15] == 5'd7);
        good    = is_pad && pc[1:0] == 2'b00 && (insn[31:12] == 20'd0 || insn[31:12] == x7[31:12]);
        chk     = m_en && m_armed && rv;
        e_ok    = chk && good;
        e_viol  = chk && !good;
        nvec++;
        cmp(tag, "lp_ok", {31'd0, lp_ok}, {31'd0, e_ok});
        cmp(tag, "viol", {31'd0, viol}, {31'd0, e_viol});
        cmp(tag, "cause", {27'd0, cause}, e_viol ? 32'd18 : 32'd0);
        cmp(tag, "tval", tval, e_viol ? 32'd2 : 32'd0);
        cmp(tag, "armed", {31'd0, armed}, {31'd0, m_armed});
        cmp(tag, "enable", {31'd0, ten}, {31'd0, m_en});
        if (rst) begin
            m_en = 0; m_lock = 0; m_armed = 0;
        end else begin
            en_nx = m_en;
            if (cwr) begin
                if (!(m_lock && !cen)) en_nx = cen;
                if (clk_lock) m_lock = 1;
            end
            if (!m_en || !en_nx || trap) m_armed = 0;
            else if (rv) m_armed = !m_armed && is_jump && !exempt;
            m_en = en_nx;
        end
        n_rv = 0; n_trap = 0; n_wr = 0; n_insn = NOP;
    endtask

    task automatic ret(input logic [31:0] i, input logic [31:0] p, input logic [31:0] v, input string tag);
        n_rv = 1; n_insn = i; n_pc = p; n_x7 = v; tick(tag);
    endtask
    task automatic cfg(input logic e, input logic l, input string tag);
        n_wr = 1; n_en = e; n_lk = l; tick(tag);
    endtask
    task automatic idle(input string tag);
        tick(tag);
    endtask

    initial begin
        #1_000_000;
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        rst = 1; rv = 0; insn = NOP; pc = 0; x7 = 0; trap = 0; cwr = 0; cen = 0; clk_lock = 0;
        repeat (2) @(posedge clk);
        idle("R1"); idle("R1");
        n_rst = 0;
        idle("R1");
        // disabled: nothing arms (R12)
        ret(jalr(10, 1), 32'h100, 0, "R12");
        ret(NOP, 32'h200, 0, "R12");
        cfg(1, 0, "R12");
        idle("R12");
        // arm and pass with zero label (R2, R7)
        ret(jalr(10, 1), 32'h100, 0, "R2");
        ret(lpad(20'd0), 32'h400, 32'hDEAD_BEEF, "R7");
        // exempt sources (R3)
        ret(jalr(1, 0), 32'h104, 0, "R3");
        ret(jalr(5, 0), 32'h108, 0, "R3");
        ret(jalr(7, 0), 32'h10C, 0, "R3");
        ret(NOP, 32'h110, 0, "R3");
        // unarmed landing pad is a hint (R4)
        ret(lpad(20'h00ABC), 32'h114, 0, "R4");
        // missing pad (R5)
        ret(jalr(6, 1), 32'h118, 0, "R2");
        ret(NOP, 32'h500, 0, "R5");
        ret(jalr(6, 1), 32'h11C, 0, "R2");
        ret({20'd0, 5'd3, 7'b0010111}, 32'h504, 0, "R5");
        ret(jalr(6, 1), 32'h120, 0, "R2");
        ret(jalr(11, 1), 32'h508, 0, "R5");
        idle("R10");
        // misaligned (R6)
        ret(jalr(12, 1), 32'h124, 0, "R2");
        ret(lpad(20'd0), 32'h602, 0, "R6");
        // label match and mismatch (R8)
        ret(jalr(12, 1), 32'h128, 0, "R2");
        ret(lpad(20'h12345), 32'h700, 32'h1234_5ABC, "R8");
        ret(jalr(12, 1), 32'h12C, 0, "R2");
        ret(lpad(20'h12345), 32'h704, 32'h1234_6ABC, "R8");
        // armed survives idle cycles (R10)
        ret(jalr(13, 1), 32'h130, 0, "R10");
        idle("R10"); idle("R10"); idle("R10");
        ret(lpad(20'h00001), 32'h708, 32'h0000_1FFF, "R10");
        ret(lpad(20'd0), 32'h70C, 0, "R10");
        // other trap (R11)
        ret(jalr(13, 1), 32'h134, 0, "R11");
        n_trap = 1; idle("R11");
        ret(NOP, 32'h710, 0, "R11");
        n_trap = 1; ret(jalr(13, 1), 32'h138, 0, "R11");
        ret(NOP, 32'h714, 0, "R11");
        // disabling clears armed (R12)
        ret(jalr(14, 1), 32'h13C, 0, "R12");
        cfg(0, 0, "R12");
        ret(NOP, 32'h718, 0, "R12");
        cfg(1, 0, "R12");
        // lock (R13)
        cfg(1, 1, "R13");
        cfg(0, 0, "R13");
        idle("R13");
        ret(jalr(15, 1), 32'h140, 0, "R13");
        ret(NOP, 32'h71C, 0, "R13");
        // mixed traffic, every cycle compared (R9)
        for (int k = 0; k < 600; k++) begin
            int sel = $urandom_range(0, 9);
            logic [19:0] lb = ($urandom_range(0, 2) == 0) ? 20'd0 : {16'd0, 4'($urandom_range(1, 3))};
            logic [31:0] xv = {16'd0, 4'($urandom_range(1, 3)), 12'($urandom)};
            logic [31:0] pv = {$urandom} & (($urandom_range(0, 4) == 0) ? 32'hFFFF_FFFE : 32'hFFFF_FFFC);
            n_rv = ($urandom_range(0, 3) != 0);
            n_trap = ($urandom_range(0, 15) == 0);
            n_pc = pv; n_x7 = xv;
            case (sel)
                0, 1, 2: n_insn = jalr($urandom_range(0, 15), 1);
                3, 4, 5: n_insn = lpad(lb);
                6:       n_insn = {lb, 5'd2, 7'b0010111};
                default: n_insn = NOP;
            endcase
            if (k == 300) begin n_rst = 1; end
            if (k == 302) begin n_rst = 0; end
            if (k == 303) begin n_wr = 1; n_en = 1; n_lk = 0; end
            tick("R9");
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule